// File: doc/BRIEF.md
# DMA Page Permission Checker

This block decides whether a memory access started by a device may proceed. Each request carries the requester's bus/device identifier and a physical address. The identifier is first turned into a protection domain through a programmable table. The page number of the address then selects one bit in that domain's exclusion bitmap. Each domain has its own bitmap, with one bit per 4 KiB page. The block answers allow or deny a fixed two cycles later. It accepts a new request every cycle. Each denial also raises a one-cycle violation report that a logger can capture.

Software fills both tables through a single write port. A write either sets a requester's table entry (valid flag and domain number) or replaces one 32-bit bitmap word. The bitmaps are held on chip and cover a reduced physical address space, set by a parameter. Every device request is checked, and the address type (DRAM or memory-mapped I/O) plays no part in the decision.

Top module: `dma_page_guard`

## Requirements
- R1: A request presented with `reqValid` high in cycle t produces `rspValid` high in cycle t+2 and in no other cycle. Back-to-back requests give back-to-back responses, and `rspValid` is low two cycles after any idle cycle.
- R2: A requester whose table entry is not valid is denied, whatever the bitmap contents are.
- R3: A write with `cfgSel`=0 sets the table entry for requester `cfgIndex[ID_W-1:0]`. `cfgData[31]` is the valid flag and `cfgData[DOM_W-1:0]` is the domain number.
- R4: A write with `cfgSel`=1 replaces bitmap word `cfgIndex[BM_IDX_W-1:0]`. That index is formed as {domain, page index >> 5}, and page index bits [4:0] pick the bit within the word. A set bit denies the access and a clear bit allows it.
- R5: The page index is `reqAddr >> 12`. Address bits [11:0] have no effect on the decision.
- R6: A request is judged only by the bitmap of the domain its requester maps to. Changing another domain's words does not change the result.
- R7: A configuration write presented in cycle c affects requests presented in cycle c+1 and later. Requests presented in cycle c or earlier use the old contents.
- R8: Every denied response has `violValid` high in the same cycle, with `violId` set to the requester ID and `violPage` set to the page index. `violValid` is never high with an allowed or absent response.
- R9: While reset is held, `rspValid` and `violValid` are low. After reset every table entry is invalid and every bitmap word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A device request is present |
| reqId | input | ID_W | Requester bus/device identifier |
| reqAddr | input | ADDR_W | Physical byte address of the access |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0: requester table entry, 1: bitmap word |
| cfgIndex | input | CFG_IDX_W | Requester ID, or {domain, word} for a bitmap word |
| cfgData | input | 32 | Table entry fields or bitmap word value |
| rspValid | output | 1 | Decision is present |
| rspAllow | output | 1 | 1 = access allowed, 0 = denied |
| violValid | output | 1 | One-cycle pulse for a denied access |
| violId | output | ID_W | Requester ID of the denied access |
| violPage | output | ADDR_W-12 | Page index of the denied access |

## Verification
The assertions assume that `reqValid`, `reqId` and `reqAddr` are driven to known values from the first clock edge, and that no request is presented while reset is held. This lets the latency and violation-field properties look back two cycles safely. The stimulus holds every input at zero through reset and changes inputs only on the falling edge. It draws requester IDs from a small set, so that mapped, unmapped and remapped requesters all occur. The random configuration writes often land in the same cycle as a request to the word they change, which exercises the ordering rule for writes and requests.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic s1Load;    // capture incoming request into stage 1
    logic s2Load;    // produce a decision from stage 1
    logic mapWr;     // write requester table entry now
    logic bmCapture; // latch a bitmap write for the next cycle
    logic bmCommit;  // commit the latched bitmap write
  } dpcStrobe_t;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cfgWrEn,
  input  logic       cfgSel,
  output dpcStrobe_t strobe,
  output logic       rspValid
);
  logic s1ValidQ;
  logic s2ValidQ;
  logic bmPendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1ValidQ <= 1'b0;
      s2ValidQ <= 1'b0;
      bmPendQ  <= 1'b0;
    end else begin
      s1ValidQ <= reqValid;
      s2ValidQ <= s1ValidQ;
      // bitmap writes land one edge late so the request accepted alongside
      // still reads the previous word in its second stage
      bmPendQ  <= cfgWrEn & cfgSel;
    end
  end

  always_comb begin
    strobe.s1Load    = reqValid;
    strobe.s2Load    = s1ValidQ;
    strobe.mapWr     = cfgWrEn & ~cfgSel;
    strobe.bmCapture = cfgWrEn & cfgSel;
    strobe.bmCommit  = bmPendQ;
  end

  assign rspValid = s2ValidQ;
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int DOM_W     = 2,
  parameter int ADDR_W    = 20,
  parameter int CFG_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpcStrobe_t           strobe,
  input  logic [ID_W-1:0]      reqId,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [CFG_IDX_W-1:0] cfgIndex,
  input  logic [31:0]          cfgData,
  output logic                 rspAllow,
  output logic                 violValid,
  output logic [ID_W-1:0]      violId,
  output logic [ADDR_W-13:0]   violPage
);
  localparam int PAGE_W     = ADDR_W - 12;
  localparam int WORD_IDX_W = PAGE_W - 5;
  localparam int BM_IDX_W   = DOM_W + WORD_IDX_W;
  localparam int BM_WORDS   = 1 << BM_IDX_W;
  localparam int ENTRIES    = 1 << ID_W;

  // ---------------- requester-to-domain table ----------------
  logic             mapValid [ENTRIES];
  logic [DOM_W-1:0] mapDom   [ENTRIES];

  for (genvar ge = 0; ge < ENTRIES; ge++) begin : gEntry
    logic             validQ;
    logic [DOM_W-1:0] domQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        domQ   <= '0;
      end else if (strobe.mapWr && cfgIndex[ID_W-1:0] == ID_W'(ge)) begin
        validQ <= cfgData[31];
        domQ   <= cfgData[DOM_W-1:0];
      end
    end
    assign mapValid[ge] = validQ;
    assign mapDom[ge]   = domQ;
  end

  // ---------------- exclusion bitmap words ----------------
  logic [BM_IDX_W-1:0] bmWrIdxQ;
  logic [31:0]         bmWrDataQ;
  logic [31:0]         bmWord [BM_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bmWrIdxQ  <= '0;
      bmWrDataQ <= '0;
    end else if (strobe.bmCapture) begin
      bmWrIdxQ  <= cfgIndex[BM_IDX_W-1:0];
      bmWrDataQ <= cfgData;
    end
  end

  for (genvar gw = 0; gw < BM_WORDS; gw++) begin : gWord
    logic [31:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= '0;
      else if (strobe.bmCommit && bmWrIdxQ == BM_IDX_W'(gw))
        wordQ <= bmWrDataQ;
    end
    assign bmWord[gw] = wordQ;
  end

  // ---------------- stage 1: domain lookup ----------------
  logic [ID_W-1:0]   s1Id;
  logic [PAGE_W-1:0] s1Page;
  logic              s1Hit;
  logic [DOM_W-1:0]  s1Dom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Id   <= '0;
      s1Page <= '0;
      s1Hit  <= 1'b0;
      s1Dom  <= '0;
    end else if (strobe.s1Load) begin
      s1Id   <= reqId;
      s1Page <= reqAddr[ADDR_W-1:12];
      s1Hit  <= mapValid[reqId];
      s1Dom  <= mapDom[reqId];
    end
  end

  // ---------------- stage 2: bitmap read and decision ----------------
  logic [BM_IDX_W-1:0] rdIdx;
  logic [31:0]         rdWord;
  logic                excluded;
  logic                allowNext;

  always_comb begin
    rdIdx     = {s1Dom, s1Page[PAGE_W-1:5]};
    rdWord    = bmWord[rdIdx];
    excluded  = rdWord[s1Page[4:0]];
    allowNext = s1Hit & ~excluded;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAllow  <= 1'b0;
      violValid <= 1'b0;
      violId    <= '0;
      violPage  <= '0;
    end else begin
      rspAllow  <= strobe.s2Load & allowNext;
      violValid <= strobe.s2Load & ~allowNext;
      if (strobe.s2Load) begin
        violId   <= s1Id;
        violPage <= s1Page;
      end
    end
  end
endmodule

// File: rtl/dma_page_guard.sv
module dma_page_guard
  import dpc_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int DOM_W  = 2,
  parameter int ADDR_W = 20,
  localparam int BM_IDX_W  = DOM_W + ADDR_W - 17,
  localparam int CFG_IDX_W = (ID_W > BM_IDX_W) ? ID_W : BM_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqId,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 cfgWrEn,
  input  logic                 cfgSel,
  input  logic [CFG_IDX_W-1:0] cfgIndex,
  input  logic [31:0]          cfgData,
  output logic                 rspValid,
  output logic                 rspAllow,
  output logic                 violValid,
  output logic [ID_W-1:0]      violId,
  output logic [ADDR_W-13:0]   violPage
);
  dpcStrobe_t strobe;

  dpc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  dpc_datapath #(
    .ID_W      (ID_W),
    .DOM_W     (DOM_W),
    .ADDR_W    (ADDR_W),
    .CFG_IDX_W (CFG_IDX_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqId     (reqId),
    .reqAddr   (reqAddr),
    .cfgIndex  (cfgIndex),
    .cfgData   (cfgData),
    .rspAllow  (rspAllow),
    .violValid (violValid),
    .violId    (violId),
    .violPage  (violPage)
  );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ID_W-1:0]   reqId,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspAllow,
  input logic              violValid,
  input logic [ID_W-1:0]   violId,
  input logic [ADDR_W-13:0] violPage
);
  // R1: a request yields a response two cycles on
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ##1 rspValid);

  // R1: an idle cycle yields no response two cycles on
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ##1 !rspValid);

  // R8: a violation only accompanies a denied response
  a_r8_viol_is_deny: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> (rspValid && !rspAllow));

  // R8: every denied response carries a violation
  a_r8_deny_reports: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAllow) |-> violValid);

  // R8: violation fields name the originating request
  a_r8_viol_fields: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ##1 (!violValid ||
      (violId == $past(reqId, 2) && violPage == $past(reqAddr[ADDR_W-1:12], 2))));

  // R9: quiet outputs while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_reset_quiet: assert (!rspValid && !violValid);
    end
  end
endmodule

bind dma_page_guard dpc_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_dma_page_guard.sv
module tb_dma_page_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W   = 8;
  localparam int DOM_W  = 2;
  localparam int ADDR_W = 20;
  localparam int PAGE_W = ADDR_W - 12;
  localparam int CFG_IDX_W = 8;
  localparam int BM_WORDS = 1 << (DOM_W + PAGE_W - 5);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ID_W-1:0] reqId = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic cfgWrEn = 1'b0;
  logic cfgSel = 1'b0;
  logic [CFG_IDX_W-1:0] cfgIndex = '0;
  logic [31:0] cfgData = '0;
  logic rspValid, rspAllow, violValid;
  logic [ID_W-1:0] violId;
  logic [PAGE_W-1:0] violPage;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_guard #(.ID_W(ID_W), .DOM_W(DOM_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId), .reqAddr(reqAddr),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgIndex(cfgIndex), .cfgData(cfgData),
    .rspValid(rspValid), .rspAllow(rspAllow), .violValid(violValid),
    .violId(violId), .violPage(violPage)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // reference state
  logic             mValid [1 << ID_W];
  logic [DOM_W-1:0] mDom   [1 << ID_W];
  logic [31:0]      mBm    [BM_WORDS];

  // expected pipeline: stage 1 is newest
  bit e1v, e2v, e1a, e2a;
  logic [ID_W-1:0] e1id, e2id;
  logic [PAGE_W-1:0] e1pg, e2pg;
  string e1tag, e2tag, curTag;

  function automatic bit expAllow(logic [ID_W-1:0] id, logic [ADDR_W-1:0] addr);
    logic [PAGE_W-1:0] pg;
    logic [31:0] w;
    pg = addr[ADDR_W-1:12];
    w = mBm[{mDom[id], pg[PAGE_W-1:5]}];
    return mValid[id] && !w[pg[4:0]];
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    nFails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic checkOut();
    nChecks++;
    if (rspValid !== e2v) fail(e2tag, "rspValid", int'(rspValid), int'(e2v));
    else if (e2v && rspAllow !== e2a) fail(e2tag, "rspAllow", int'(rspAllow), int'(e2a));
    else if (violValid !== (e2v && !e2a)) fail(e2tag, "violValid", int'(violValid), int'(e2v && !e2a));
    else if (violValid && violId !== e2id) fail(e2tag, "violId", int'(violId), int'(e2id));
    else if (violValid && violPage !== e2pg) fail(e2tag, "violPage", int'(violPage), int'(e2pg));
  endtask

  // one cycle: check, drive, predict, update model (R7: write seen by later requests only)
  task automatic step(bit rv, int id, int addr, bit we, bit sel, int idx, logic [31:0] d);
    @(negedge clk);
    checkOut();
    e2v = e1v; e2a = e1a; e2id = e1id; e2pg = e1pg; e2tag = e1tag;
    reqValid = rv; reqId = ID_W'(id); reqAddr = ADDR_W'(addr);
    cfgWrEn = we; cfgSel = sel; cfgIndex = CFG_IDX_W'(idx); cfgData = d;
    e1v = rv; e1id = ID_W'(id); e1pg = reqAddr[ADDR_W-1:12]; e1tag = curTag;
    e1a = rv ? expAllow(ID_W'(id), ADDR_W'(addr)) : 1'b0;
    if (we && !sel) begin
      mValid[idx[ID_W-1:0]] = d[31];
      mDom[idx[ID_W-1:0]] = d[DOM_W-1:0];
    end else if (we && sel) begin
      mBm[idx % BM_WORDS] = d;
    end
  endtask

  task automatic req(int id, int addr);
    step(1'b1, id, addr, 1'b0, 1'b0, 0, 32'h0);
  endtask

  task automatic mapId(int id, int dom, bit v);
    step(1'b0, 0, 0, 1'b1, 1'b0, id, {v, 29'h0, 2'(dom)});
  endtask

  task automatic bmWrite(int dom, int word, logic [31:0] d);
    step(1'b0, 0, 0, 1'b1, 1'b1, (dom << (PAGE_W - 5)) | word, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, 0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < (1 << ID_W); i++) begin mValid[i] = 1'b0; mDom[i] = '0; end
    for (int i = 0; i < BM_WORDS; i++) mBm[i] = '0;
    e1v = 0; e2v = 0; e1a = 0; e2a = 0; e1id = '0; e2id = '0; e1pg = '0; e2pg = '0;
    e1tag = "R1"; e2tag = "R1"; curTag = "R1";

    // R9: outputs quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      nChecks++;
      if (rspValid !== 1'b0 || violValid !== 1'b0)
        fail("R9", "reset outputs", int'({rspValid, violValid}), 0);
    end
    rstN = 1'b1;

    // R2 / R9: empty table denies
    curTag = "R2"; req(5, 32'h23000);
    // R3: map ID 5 to domain 1; R9: cleared bitmap allows
    curTag = "R3"; mapId(5, 1, 1'b1);
    curTag = "R9"; req(5, 32'h23000);
    // R4: exclude page 0x23 of domain 1 (word 1, bit 3)
    curTag = "R4"; bmWrite(1, 1, 32'h0000_0008);
    idle(1);
    req(5, 32'h23000); req(5, 32'h22000);
    // R5: low 12 bits ignored
    curTag = "R5"; req(5, 32'h23FFF); req(5, 32'h22ABC);
    // R6: ID 6 in domain 2 sees no exclusion; write to domain 3 leaves ID 5 unchanged
    curTag = "R6"; mapId(6, 2, 1'b1); req(6, 32'h23000);
    bmWrite(3, 1, 32'hFFFF_FFFF); idle(1); req(5, 32'h22000);
    // R7: request alongside bitmap clear uses old word, next one uses new
    curTag = "R7"; step(1'b1, 5, 32'h23000, 1'b1, 1'b1, (1 << 3) | 1, 32'h0);
    req(5, 32'h23000);
    // R7: request alongside table invalidation still mapped, next denied
    step(1'b1, 5, 32'h23000, 1'b1, 1'b0, 5, 32'h0);
    curTag = "R2"; req(5, 32'h23000);
    // R8: violation fields for deny of ID 0x9A
    curTag = "R8"; req(8'h9A, 32'hFF123);
    // R1: gaps and back-to-back
    curTag = "R1"; idle(2); req(6, 32'h01000); req(6, 32'h02000); idle(3);

    // constrained random mix
    curTag = "R6";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      bit rv = (r < 70);
      bit we = ($urandom % 100) < 30;
      bit sel = $urandom % 2;
      int idx = sel ? int'($urandom % BM_WORDS) : int'($urandom % 16);
      logic [31:0] d = sel ? $urandom : {($urandom % 4) != 0, 29'h0, 2'($urandom)};
      step(rv, int'($urandom % 16), int'($urandom % (1 << ADDR_W)), we, sel, idx, d);
    end
    idle(3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule